// File: doc/BRIEF.md
# Flash Command Register Controller

This block is the command front end of a byte-wide electrically erasable memory. Bus write cycles carry 8-bit command codes into a command register. A state machine decodes them into array read, identifier read, erase, erase verify, program, program verify and reset. The same write cycles latch the address and data that a later program or erase step needs. A behavioural register array stands in for the memory cells. An erase pulse sets every byte to 0xFF. A program pulse ANDs the latched data into the latched byte.

Pulses have no outside maximum length. A pulse ends at the next command write, which is normally the matching verify code. If no write arrives, an internal stop timer ends the pulse after `PULSE_CYC` clock cycles. After that the controller sits in a halted state and accepts only a verify code or a double reset. A high-voltage-present input gates all of this. While it is low, every write is ignored and the part reads as a plain read-only memory. A drop of that input aborts a running pulse without touching the array.

A write cycle is any clock edge that samples `ce_n` and `we_n` both low. The read data path is combinational from the address and the current mode.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: While `hv_ok` is low, writes have no effect: no command is taken, no pulse starts and reads return array data.
- R2: `dout_en` is 1 only when `ce_n`=0, `oe_n`=0 and `we_n`=1. In every other case `dout_en` is 0 and `dout` is 0x00, whatever the mode.
- R3: After a 0x90 write, reads return `MFG_CODE` (default 0x89) when `addr[0]`=0 and `DEV_CODE` (default 0xB4) when `addr[0]`=1. A 0x00 write returns reads to array data.
- R4: Writing 0x20 and then 0x20 again starts an erase pulse, and `busy` goes to 1. A following 0xA0 write ends the pulse, leaves every byte at 0xFF and selects erase verify. Erase verify reads the byte at the address latched with the 0xA0 write.
- R5: If the write after a 0x20 is not 0x20, the controller returns to array read. No pulse starts, the array is unchanged, and the next write is decoded as a command.
- R6: Writing 0x40 and then a data write starts a program pulse that uses the address and data of that data write. A following 0xC0 write ends the pulse and leaves that byte equal to its old value AND the data. Program verify reads the latched byte whatever the bus address.
- R7: If no write arrives, `busy` stays 1 for exactly `PULSE_CYC` cycles after the pulse-starting write. The erase or program effect is still applied.
- R8: After the stop timer fires, writes other than 0xA0, 0xC0 or 0xFF are ignored, and reads return array data.
- R9: Two consecutive 0xFF writes return the controller to array read, including from the halted state. A single 0xFF followed by another code does not reset.
- R10: A fall of `hv_ok` during a pulse clears `busy` on the next clock, applies no array change and returns to array read.
- R11: Any write during a pulse ends it, applies the effect, and is then decoded as a command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data / command code |
| dout | output | 8 | Read data, 0x00 when not driven |
| dout_en | output | 1 | Read data valid on the bus |
| hv_ok | input | 1 | High programming voltage present |
| busy | output | 1 | Program or erase pulse running |

## Verification
The pulse logic is driven in three ways: the matching verify code ends the pulse, an unrelated code ends it, and no write arrives so the timer ends it. Comparing the three shows whether the array effect and the next mode depend only on the pulse ending, not on how it ended. Program data is ANDed twice into one byte. This separates AND from overwrite, and verify reads use a bus address different from the latched one, so a latch fault cannot hide. Reset is tried with single and double 0xFF writes, from identifier mode and from the halted state. Writes with `hv_ok` low and mid-pulse voltage drops show that the gate stops commands and discards the effect.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    FS_READ,
    FS_IDENT,
    FS_ERS_ARM,
    FS_ERS_PULSE,
    FS_ERS_CHECK,
    FS_PRG_ARM,
    FS_PRG_PULSE,
    FS_PRG_CHECK,
    FS_HALTED
  } fc_state_e;

  localparam logic [7:0] CMD_READ  = 8'h00;
  localparam logic [7:0] CMD_IDENT = 8'h90;
  localparam logic [7:0] CMD_ERASE = 8'h20;
  localparam logic [7:0] CMD_EVFY  = 8'hA0;
  localparam logic [7:0] CMD_PROG  = 8'h40;
  localparam logic [7:0] CMD_PVFY  = 8'hC0;
  localparam logic [7:0] CMD_RESET = 8'hFF;

endpackage

// File: rtl/fc_stop_timer.sv
module fc_stop_timer #(
  parameter int PULSE_CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic clear,
  output logic expire,
  output logic running
);
  localparam int CW = $clog2(PULSE_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_CYC);
  localparam logic [CW-1:0] LAST = CW'(1);

  logic          run_q, run_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expire  = run_q && (cnt_q == LAST);
  assign running = run_q;

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (clear || expire) begin
      run_d = 1'b0;
    end else if (start) begin
      run_d  = 1'b1;
      cnt_d  = LOAD;
      cnt_en = 1'b1;
    end else if (run_q) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/fc_cell_array.sv
module fc_cell_array #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              erase_all,
  input  logic              prog_en,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [7:0]        prog_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic [ADDR_W-1:0] vfy_addr,
  output logic [7:0]        vfy_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cells [DEPTH];

  assign rd_data  = cells[rd_addr];
  assign vfy_data = cells[vfy_addr];

  always_ff @(posedge clk) begin
    if (erase_all) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
    end else if (prog_en) begin
      cells[prog_addr] <= cells[prog_addr] & prog_data;
    end
  end
endmodule

// File: rtl/fc_cmd_fsm.sv
module fc_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hv_ok,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic              tmr_expire,
  output fc_state_e         st_q,
  output logic              tmr_start,
  output logic              tmr_clear,
  output logic              erase_all,
  output logic              prog_en,
  output logic [ADDR_W-1:0] prg_addr,
  output logic [7:0]        prg_data,
  output logic [ADDR_W-1:0] vfy_addr
);
  fc_state_e         st_d, keep_st, gen_st;
  logic              pend_q, pend_d, gen_pend;
  logic              gen_ers_ld, ers_ld, prg_ld;
  logic              wr, in_pulse, pulse_end, halt_ok;
  logic [ADDR_W-1:0] ers_addr_q;
  logic [ADDR_W-1:0] prg_addr_q;
  logic [7:0]        prg_data_q;

  assign wr       = wr_stb && hv_ok;
  assign in_pulse = (st_q == FS_ERS_PULSE) || (st_q == FS_PRG_PULSE);
  assign halt_ok  = (din == CMD_EVFY) || (din == CMD_PVFY) || (din == CMD_RESET);

  // general command decode
  always_comb begin
    keep_st    = in_pulse ? FS_HALTED : st_q;
    gen_st     = keep_st;
    gen_ers_ld = 1'b0;
    gen_pend   = (din == CMD_RESET) && !pend_q;
    case (din)
      CMD_READ:  gen_st = FS_READ;
      CMD_IDENT: gen_st = FS_IDENT;
      CMD_ERASE: gen_st = FS_ERS_ARM;
      CMD_EVFY:  begin gen_st = FS_ERS_CHECK; gen_ers_ld = 1'b1; end
      CMD_PROG:  gen_st = FS_PRG_ARM;
      CMD_PVFY:  gen_st = FS_PRG_CHECK;
      CMD_RESET: gen_st = pend_q ? FS_READ : keep_st;
      default:   gen_st = keep_st;
    endcase
  end

  // next state
  always_comb begin
    st_d      = st_q;
    pend_d    = pend_q;
    ers_ld    = 1'b0;
    prg_ld    = 1'b0;
    tmr_start = 1'b0;
    pulse_end = 1'b0;
    if (!hv_ok) begin
      st_d   = FS_READ;
      pend_d = 1'b0;
    end else begin
      case (st_q)
        FS_ERS_ARM: if (wr) begin
          pend_d = 1'b0;
          if (din == CMD_ERASE) begin
            st_d      = FS_ERS_PULSE;
            tmr_start = 1'b1;
          end else begin
            st_d = FS_READ;
          end
        end
        FS_PRG_ARM: if (wr) begin
          pend_d    = 1'b0;
          prg_ld    = 1'b1;
          st_d      = FS_PRG_PULSE;
          tmr_start = 1'b1;
        end
        FS_ERS_PULSE, FS_PRG_PULSE: begin
          if (wr) begin
            pulse_end = 1'b1;
            st_d      = gen_st;
            pend_d    = gen_pend;
            ers_ld    = gen_ers_ld;
          end else if (tmr_expire) begin
            pulse_end = 1'b1;
            st_d      = FS_HALTED;
          end
        end
        FS_HALTED: if (wr) begin
          if (halt_ok) begin
            st_d   = gen_st;
            pend_d = gen_pend;
            ers_ld = gen_ers_ld;
          end else begin
            pend_d = 1'b0;
          end
        end
        default: if (wr) begin
          st_d   = gen_st;
          pend_d = gen_pend;
          ers_ld = gen_ers_ld;
        end
      endcase
    end
  end

  assign tmr_clear = pulse_end || !hv_ok;
  assign erase_all = pulse_end && (st_q == FS_ERS_PULSE);
  assign prog_en   = pulse_end && (st_q == FS_PRG_PULSE);
  assign prg_addr  = prg_addr_q;
  assign prg_data  = prg_data_q;
  assign vfy_addr  = (st_q == FS_ERS_CHECK) ? ers_addr_q : prg_addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= FS_READ;
      pend_q     <= 1'b0;
      ers_addr_q <= '0;
      prg_addr_q <= '0;
      prg_data_q <= '0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      if (ers_ld) ers_addr_q <= addr;
      if (prg_ld) begin
        prg_addr_q <= addr;
        prg_data_q <= din;
      end
    end
  end
endmodule

// File: rtl/fc_read_mux.sv
module fc_read_mux
  import flash_cmd_pkg::*;
#(
  parameter logic [7:0] MFG_CODE = 8'h89,
  parameter logic [7:0] DEV_CODE = 8'hB4
) (
  input  logic       ce_n,
  input  logic       oe_n,
  input  logic       we_n,
  input  logic       addr_lsb,
  input  fc_state_e  st,
  input  logic [7:0] arr_data,
  input  logic [7:0] vfy_data,
  output logic [7:0] dout,
  output logic       dout_en
);
  logic [7:0] sel;

  always_comb begin
    case (st)
      FS_IDENT:                   sel = addr_lsb ? DEV_CODE : MFG_CODE;
      FS_ERS_CHECK, FS_PRG_CHECK: sel = vfy_data;
      default:                    sel = arr_data;
    endcase
  end

  assign dout_en = !ce_n && !oe_n && we_n;
  assign dout    = dout_en ? sel : 8'h00;
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int         ADDR_W    = 8,
  parameter int         PULSE_CYC = 10,
  parameter logic [7:0] MFG_CODE  = 8'h89,
  parameter logic [7:0] DEV_CODE  = 8'hB4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_en,
  input  logic              hv_ok,
  output logic              busy
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_i;
  logic              wr_stb;
  fc_state_e         fsm_st;
  logic              tmr_start, tmr_clear, tmr_expire, tmr_run;
  logic              erase_all, prog_en;
  logic [ADDR_W-1:0] prg_addr, vfy_addr;
  logic [7:0]        prg_data, arr_rd, vfy_rd;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  assign wr_stb = !ce_n && !we_n;
  assign busy   = tmr_run;

  fc_cmd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .hv_ok     (hv_ok),
    .wr_stb    (wr_stb),
    .addr      (addr),
    .din       (din),
    .tmr_expire(tmr_expire),
    .st_q      (fsm_st),
    .tmr_start (tmr_start),
    .tmr_clear (tmr_clear),
    .erase_all (erase_all),
    .prog_en   (prog_en),
    .prg_addr  (prg_addr),
    .prg_data  (prg_data),
    .vfy_addr  (vfy_addr)
  );

  fc_stop_timer #(.PULSE_CYC(PULSE_CYC)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .start  (tmr_start),
    .clear  (tmr_clear),
    .expire (tmr_expire),
    .running(tmr_run)
  );

  fc_cell_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk      (clk),
    .erase_all(erase_all),
    .prog_en  (prog_en),
    .prog_addr(prg_addr),
    .prog_data(prg_data),
    .rd_addr  (addr),
    .rd_data  (arr_rd),
    .vfy_addr (vfy_addr),
    .vfy_data (vfy_rd)
  );

  fc_read_mux #(.MFG_CODE(MFG_CODE), .DEV_CODE(DEV_CODE)) u_rmux (
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .we_n    (we_n),
    .addr_lsb(addr[0]),
    .st      (fsm_st),
    .arr_data(arr_rd),
    .vfy_data(vfy_rd),
    .dout    (dout),
    .dout_en (dout_en)
  );
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk
  import flash_cmd_pkg::*;
#(
  parameter int PULSE_CYC = 10
) (
  input logic       clk,
  input logic       rst_n,
  input logic       hv_ok,
  input logic       ce_n,
  input logic       we_n,
  input logic [7:0] din,
  input fc_state_e  st,
  input logic       erase_all,
  input logic [7:0] arr_rd,
  input logic       busy
);
  localparam int CW = $clog2(PULSE_CYC + 2);
  localparam logic [CW-1:0] LIM = CW'(PULSE_CYC);

  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  assert_hv_low_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !hv_ok |=> (st == FS_READ));

  assert_erase_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    erase_all |=> (arr_rd == 8'hFF));

  assert_busy_in_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy == ((st == FS_ERS_PULSE) || (st == FS_PRG_PULSE)));

  assert_pulse_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_cnt < LIM));

  assert_halt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FS_HALTED && hv_ok && !ce_n && !we_n &&
     din != CMD_EVFY && din != CMD_PVFY && din != CMD_RESET) |=> (st == FS_HALTED));

  assert_hv_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !hv_ok) |=> !busy);
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .hv_ok    (hv_ok),
  .ce_n     (ce_n),
  .we_n     (we_n),
  .din      (din),
  .st       (fsm_st),
  .erase_all(erase_all),
  .arr_rd   (arr_rd),
  .busy     (busy)
);

// File: tb/test_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module test_flash_cmd_ctrl;
  localparam int ADDR_W = 8;
  localparam int PULSE_CYC = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0]        din = '0;
  logic [7:0]        dout;
  logic              dout_en;
  logic              hv_ok = 1'b0;
  logic              busy;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(ADDR_W), .PULSE_CYC(PULSE_CYC)) i_flash_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
    .hv_ok(hv_ok), .busy(busy)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    #2 d = dout;
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic t_reset_R2;
    logic [7:0] v;
    chk("R2 reset busy", {7'd0, busy}, 8'h00);
    chk("R2 idle dout_en", {7'd0, dout_en}, 8'h00);
    chk("R2 idle dout", dout, 8'h00);
    hv_ok = 1'b1;
    wr(0, 8'h20); wr(0, 8'h20); wr(0, 8'hA0); wr(0, 8'h00);
    @(negedge clk);
    addr = 8'd3; ce_n = 1'b1; oe_n = 1'b0;
    #2 chk("R2 ce high", {7'd0, dout_en}, 8'h00);
    chk("R2 ce high dout", dout, 8'h00);
    ce_n = 1'b0; oe_n = 1'b1;
    #1 chk("R2 oe high", {7'd0, dout_en}, 8'h00);
    ce_n = 1'b1;
    rd(3, v);
    chk("R2 enabled read", v, 8'hFF);
  endtask

  task automatic t_erase_R4;
    logic [7:0] v;
    wr(0, 8'h40); wr(5, 8'h00); wr(0, 8'hC0); wr(0, 8'h00);
    wr(0, 8'h20); wr(0, 8'h20);
    chk("R4 busy in erase", {7'd0, busy}, 8'h01);
    wr(5, 8'hA0);
    chk("R4 busy after verify", {7'd0, busy}, 8'h00);
    rd(200, v); chk("R4 erase verify byte", v, 8'hFF);
    wr(0, 8'h00);
    rd(5, v); chk("R4 erased byte 5", v, 8'hFF);
    rd(200, v); chk("R4 erased byte 200", v, 8'hFF);
  endtask

  task automatic t_prog_R6;
    logic [7:0] v;
    wr(0, 8'h40); wr(5, 8'h3C);
    chk("R6 busy in program", {7'd0, busy}, 8'h01);
    wr(0, 8'hC0);
    chk("R6 busy after verify", {7'd0, busy}, 8'h00);
    rd(9, v); chk("R6 program verify", v, 8'h3C);
    wr(0, 8'h40); wr(5, 8'hF0); wr(0, 8'hC0);
    rd(9, v); chk("R6 AND second program", v, 8'h30);
    wr(0, 8'h00);
    rd(9, v); chk("R6 other byte untouched", v, 8'hFF);
    rd(5, v); chk("R6 array byte", v, 8'h30);
  endtask

  task automatic t_timer_R7_R8;
    logic [7:0] v;
    int n;
    wr(0, 8'h40); wr(7, 8'h0F);
    n = 0;
    for (int i = 0; i < 50; i++) begin
      if (busy) n++;
      @(negedge clk);
    end
    chk("R7 busy length", 8'(n), 8'(PULSE_CYC));
    wr(0, 8'h90);
    rd(0, v); chk("R8 ident ignored when halted", v, 8'hFF);
    wr(0, 8'h00); wr(0, 8'h90);
    rd(1, v); chk("R8 still halted", v, 8'hFF);
    wr(0, 8'hFF); wr(0, 8'hFF); wr(0, 8'h90);
    rd(0, v); chk("R3 R9 mfg code after reset", v, 8'h89);
    rd(1, v); chk("R3 dev code", v, 8'hB4);
    wr(0, 8'h00);
    rd(7, v); chk("R7 timed program applied", v, 8'h0F);
  endtask

  task automatic t_reset_R9;
    logic [7:0] v;
    wr(0, 8'h90); wr(0, 8'hFF);
    rd(0, v); chk("R9 single FF no reset", v, 8'h89);
    wr(0, 8'h90); wr(0, 8'hFF);
    rd(1, v); chk("R9 FF then other no reset", v, 8'hB4);
    wr(0, 8'hFF);
    rd(0, v); chk("R9 double FF resets", v, 8'hFF);
  endtask

  task automatic t_abort_R5;
    logic [7:0] v;
    wr(0, 8'h20); wr(0, 8'h40);
    chk("R5 no pulse", {7'd0, busy}, 8'h00);
    wr(0, 8'h90);
    rd(0, v); chk("R5 next write decoded", v, 8'h89);
    wr(0, 8'h00);
    rd(5, v); chk("R5 array unchanged", v, 8'h30);
  endtask

  task automatic t_hv_R10_R1;
    logic [7:0] v;
    wr(0, 8'h40); wr(9, 8'h00);
    chk("R10 busy before drop", {7'd0, busy}, 8'h01);
    @(negedge clk); hv_ok = 1'b0;
    @(negedge clk);
    chk("R10 busy cleared", {7'd0, busy}, 8'h00);
    rd(9, v); chk("R10 no program effect", v, 8'hFF);
    wr(0, 8'h90);
    rd(0, v); chk("R1 ident ignored", v, 8'hFF);
    wr(0, 8'h20); wr(0, 8'h20);
    chk("R1 no erase pulse", {7'd0, busy}, 8'h00);
    hv_ok = 1'b1;
    rd(5, v); chk("R1 array unchanged", v, 8'h30);
  endtask

  task automatic t_other_end_R11;
    logic [7:0] v;
    wr(0, 8'h20); wr(0, 8'h20); wr(0, 8'h90);
    chk("R11 pulse ended", {7'd0, busy}, 8'h00);
    rd(0, v); chk("R11 code decoded", v, 8'h89);
    wr(0, 8'h00);
    rd(5, v); chk("R11 erase applied", v, 8'hFF);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got hang expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_R2();
    t_erase_R4();
    t_prog_R6();
    t_timer_R7_R8();
    t_reset_R9();
    t_abort_R5();
    t_hv_R10_R1();
    t_other_end_R11();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule